// File: doc/BRIEF.md
# Memory Error Reporting Register Bank

This block is the software-visible register file that sits beside an on-chip memory controller and collects its error reports. Eleven error sources arrive as single-cycle pulses; each one latches a sticky status bit that software clears by writing ones. Each source can be kept from the interrupt by a mask whose bits are changed only through two alias addresses, one that sets bits and one that clears them. The mask works as an enable: the single level interrupt is high while any status bit and its mask bit are both set.

Correctable and uncorrectable ECC events carry the failing address, 128 bits of data and a syndrome. These are held only for the first failure of each kind. A read-modify-write failure keeps its own first address. A saturating counter totals correctable events. The block also holds plain read/write control state for the controller, all brought out on ports: error response enables, ECC mode bits, monitor clear bits, fault-injection data and syndrome, a fault-injection counter, and per-bank read, write and sense timing margins. A read-only implementation register reports the memory size code chosen at elaboration.

Accesses are aligned 32-bit APB-style transfers. A three-state access machine orders them. ST_IDLE moves to ST_SETUP when select rises without enable. ST_SETUP moves to ST_ACCESS when enable is seen, and a write commits on that transition. Otherwise ST_SETUP falls back to ST_IDLE once select drops. ST_ACCESS returns to ST_IDLE, or re-enters ST_SETUP on a back-to-back setup phase.

Top module: `mem_err_regbank`

## Requirements
- R1: A write commits exactly once per transfer, at the clock edge that ends its enable phase, which must follow a setup phase. During the enable phase `prdata` shows the addressed register. Address bits 1:0 are ignored.
- R2: After reset the status reads 0, the mask reads 0x7FF, the read-margin register reads 0x249, every other register reads 0 except the size code, and `irq` is low.
- R3: Status at 0x04 holds sources in bits 10:0. Bit 0 is bad bus access, 1 power-down, 2 invalid read, 3 invalid write, 4 locked read, 5 locked write, 6 correctable ECC, 7 uncorrectable ECC, 8 fixed-burst read, 9 fixed-burst write and 10 uncorrectable during read-modify-write. An `evt` pulse on bit i sets status bit i. Writing 1 clears a bit and writing 0 leaves it unchanged. When a pulse and a clear hit the same bit in one cycle, the bit stays set. Bits 31:11 read 0.
- R4: The mask at 0x08 ignores direct writes. A write to 0x0C ORs the written bits into the mask, and a write to 0x10 clears them. Both aliases read 0.
- R5: `irq` is high exactly when (status AND mask) is nonzero. It follows the register state with no extra delay after the update edge.
- R6: On a correctable event (bit 6) with status bit 6 clear, the block captures three things. The address goes to 0x1C bits 17:0. The data goes to 0x20, 0x24, 0x28 and 0x2C, least significant word first. The syndrome goes to 0x30 bits 15:0. While bit 6 is set, later events leave the capture unchanged. Writes to these offsets are ignored.
- R7: The same first-failure rule applies to uncorrectable events (bit 7), with address at 0x34, data at 0x38 to 0x44 and syndrome at 0x48. Read-modify-write failures (bit 10) capture their address at 0x70 bits 17:0.
- R8: The counter at 0x6C bits 15:0 increments on each correctable event and saturates at 0xFFFF. Writing 1 to a bit clears it. A clear and an increment in the same cycle apply the clear first.
- R9: Offset 0x80 bits 3:0 read the size code: 64 KiB gives 0, 128 KiB gives 1, 256 KiB gives 2 and 512 KiB gives 3. Writes are ignored. Any other size stops elaboration.
- R10: The control registers are read/write and drive their ports, and their unused bits read 0. They are 0x00 bits 3:0, 0x14 bits 2:0, 0x18 bits 7:0, 0x4C to 0x58 as full words, 0x5C bits 15:0, 0x60 bits 11:0, 0x64 bits 7:0, 0x68 bits 3:0 and 0x74 bits 23:0.
- R11: Undecoded offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Enable phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| evt | input | 11 | Error source pulses, bit map as in R3 |
| ce_addr | input | 18 | Correctable failure address |
| ce_data | input | 128 | Correctable failure data |
| ce_syn | input | 16 | Correctable failure syndrome |
| ue_addr | input | 18 | Uncorrectable failure address |
| ue_data | input | 128 | Uncorrectable failure data |
| ue_syn | input | 16 | Uncorrectable failure syndrome |
| rmw_addr | input | 18 | Read-modify-write failure address |
| irq | output | 1 | Level interrupt |
| err_resp_o | output | 4 | Error response enables |
| ecc_mode_o | output | 3 | ECC mode bits |
| mon_clr_o | output | 8 | Monitor clear bits |
| inj_data_o | output | 128 | Fault-injection data |
| inj_syn_o | output | 16 | Fault-injection syndrome |
| inj_cnt_o | output | 24 | Fault-injection counter |
| mrg_rd_o | output | 12 | Read margins, 3 bits per bank |
| mrg_wr_o | output | 8 | Write margins, 2 bits per bank |
| mrg_sense_o | output | 4 | Sense margin, 1 bit per bank |

## Verification
Single source pulses show that each event reaches its own status bit, and that the interrupt follows the mask rather than the status alone. Sequences that disable, re-enable and write the mask directly show the alias path apart from the ignored direct path. Repeated correctable events separate first-failure capture from last-failure capture, and a status clear followed by a new event shows that capture re-arms. A same-cycle pulse and clear shows which side wins, and a long held pulse drives the counter into saturation.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;

    localparam int NSRC       = 11;
    localparam int SRC_CE     = 6;
    localparam int SRC_UE     = 7;
    localparam int SRC_RMW_UE = 10;

    localparam int OFF_RESP    = 'h00;
    localparam int OFF_STATUS  = 'h04;
    localparam int OFF_MASK    = 'h08;
    localparam int OFF_MSET    = 'h0C;
    localparam int OFF_MCLR    = 'h10;
    localparam int OFF_ECCMODE = 'h14;
    localparam int OFF_MONCLR  = 'h18;
    localparam int OFF_CE_ADDR = 'h1C;
    localparam int OFF_CE_D0   = 'h20;
    localparam int OFF_CE_SYN  = 'h30;
    localparam int OFF_UE_ADDR = 'h34;
    localparam int OFF_UE_D0   = 'h38;
    localparam int OFF_UE_SYN  = 'h48;
    localparam int OFF_INJ_D0  = 'h4C;
    localparam int OFF_INJ_SYN = 'h5C;
    localparam int OFF_MRG_RD  = 'h60;
    localparam int OFF_MRG_WR  = 'h64;
    localparam int OFF_MRG_SN  = 'h68;
    localparam int OFF_CE_CNT  = 'h6C;
    localparam int OFF_RMW     = 'h70;
    localparam int OFF_INJ_CNT = 'h74;
    localparam int OFF_SIZE    = 'h80;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } bus_state_t;

    function automatic logic [3:0] size_code(input int unsigned bytes);
        case (bytes)
            32'd65536:  return 4'd0;
            32'd131072: return 4'd1;
            32'd262144: return 4'd2;
            32'd524288: return 4'd3;
            default:    return 4'hF;
        endcase
    endfunction

endpackage

// File: rtl/bus_access_fsm.sv
module bus_access_fsm
    import mem_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_commit
);

    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        wr_commit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (psel && !penable) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (psel && penable) begin
                    state_d   = ST_ACCESS;
                    wr_commit = pwrite;
                end else if (!psel) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ACCESS: begin
                state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assert_single_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

endmodule

// File: rtl/err_status_mask.sv
module err_status_mask #(
    parameter int NSRC = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            st_we,
    input  logic            set_we,
    input  logic            clr_we,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] status_q,
    output logic [NSRC-1:0] mask_q,
    output logic            irq
);

    logic [NSRC-1:0] w1c;

    assign w1c = st_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '1;
        end else begin
            status_q <= (status_q & ~w1c) | evt;
            if (set_we)      mask_q <= mask_q | wdata;
            else if (clr_we) mask_q <= mask_q & ~wdata;
        end
    end

    assign irq = |(status_q & mask_q);

    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

    assert_only_evt_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt)) == '0));

    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_q));

endmodule

// File: rtl/err_capture.sv
module err_capture #(
    parameter int AW = 18,
    parameter int DW = 128,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          busy,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic [SW-1:0] syn_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic [SW-1:0] syn_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            syn_q  <= '0;
        end else if (trig && !busy) begin
            addr_q <= addr_in;
            data_q <= data_in;
            syn_q  <= syn_in;
        end
    end

    assert_first_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> ($stable(addr_q) && $stable(syn_q) && $stable(data_q)));

endmodule

// File: rtl/mem_err_regbank.sv
module mem_err_regbank
    import mem_err_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 262144,
    parameter int ADDR_W   = 12,
    parameter int MEM_AW   = 18,
    parameter int SYN_W    = 16,
    parameter int CNT_W    = 16,
    parameter int INJ_W    = 24,
    parameter int BANKS    = 4,
    parameter int DWORDS   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [NSRC-1:0]      evt,
    input  logic [MEM_AW-1:0]    ce_addr,
    input  logic [32*DWORDS-1:0] ce_data,
    input  logic [SYN_W-1:0]     ce_syn,
    input  logic [MEM_AW-1:0]    ue_addr,
    input  logic [32*DWORDS-1:0] ue_data,
    input  logic [SYN_W-1:0]     ue_syn,
    input  logic [MEM_AW-1:0]    rmw_addr,
    output logic                 irq,
    output logic [3:0]           err_resp_o,
    output logic [2:0]           ecc_mode_o,
    output logic [7:0]           mon_clr_o,
    output logic [32*DWORDS-1:0] inj_data_o,
    output logic [SYN_W-1:0]     inj_syn_o,
    output logic [INJ_W-1:0]     inj_cnt_o,
    output logic [3*BANKS-1:0]   mrg_rd_o,
    output logic [2*BANKS-1:0]   mrg_wr_o,
    output logic [BANKS-1:0]     mrg_sense_o
);

    localparam int DW = 32 * DWORDS;
    localparam logic [3:0] SIZE_CODE = size_code(MEM_BYTES);
    localparam logic [3*BANKS-1:0] MRG_RD_RST = {BANKS{3'b001}};

    if (SIZE_CODE == 4'hF) begin : g_bad_size
        $error("mem_err_regbank: unsupported MEM_BYTES");
    end

    logic [ADDR_W-1:0] a;
    logic              wr_commit;
    logic [NSRC-1:0]   status_q, mask_q;
    logic [MEM_AW-1:0] ce_addr_q, ue_addr_q, rmw_q;
    logic [DW-1:0]     ce_data_q, ue_data_q;
    logic [SYN_W-1:0]  ce_syn_q, ue_syn_q;
    logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_d;
    logic              cnt_we;

    assign a = paddr & ~ADDR_W'(3);

    function automatic logic hit(input logic [ADDR_W-1:0] adr, input int off);
        return adr == ADDR_W'(off);
    endfunction

    bus_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .wr_commit (wr_commit)
    );

    err_status_mask #(.NSRC(NSRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .st_we    (wr_commit && hit(a, OFF_STATUS)),
        .set_we   (wr_commit && hit(a, OFF_MSET)),
        .clr_we   (wr_commit && hit(a, OFF_MCLR)),
        .wdata    (pwdata[NSRC-1:0]),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

    err_capture #(.AW(MEM_AW), .DW(DW), .SW(SYN_W)) u_ce_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (evt[SRC_CE]),
        .busy    (status_q[SRC_CE]),
        .addr_in (ce_addr),
        .data_in (ce_data),
        .syn_in  (ce_syn),
        .addr_q  (ce_addr_q),
        .data_q  (ce_data_q),
        .syn_q   (ce_syn_q)
    );

    err_capture #(.AW(MEM_AW), .DW(DW), .SW(SYN_W)) u_ue_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (evt[SRC_UE]),
        .busy    (status_q[SRC_UE]),
        .addr_in (ue_addr),
        .data_in (ue_data),
        .syn_in  (ue_syn),
        .addr_q  (ue_addr_q),
        .data_q  (ue_data_q),
        .syn_q   (ue_syn_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         rmw_q <= '0;
        else if (evt[SRC_RMW_UE] && !status_q[SRC_RMW_UE]) rmw_q <= rmw_addr;
    end

    // corrected-error counter: clear first, then saturating increment
    assign cnt_we   = wr_commit && hit(a, OFF_CE_CNT);
    assign cnt_base = cnt_we ? (cnt_q & ~pwdata[CNT_W-1:0]) : cnt_q;
    assign cnt_d    = (evt[SRC_CE] && cnt_base != '1) ? cnt_base + 1'b1 : cnt_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !cnt_we) |=> (cnt_q == '1));

    // plain control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_resp_o  <= '0;
            ecc_mode_o  <= '0;
            mon_clr_o   <= '0;
            inj_data_o  <= '0;
            inj_syn_o   <= '0;
            inj_cnt_o   <= '0;
            mrg_rd_o    <= MRG_RD_RST;
            mrg_wr_o    <= '0;
            mrg_sense_o <= '0;
        end else if (wr_commit) begin
            if (hit(a, OFF_RESP))    err_resp_o  <= pwdata[3:0];
            if (hit(a, OFF_ECCMODE)) ecc_mode_o  <= pwdata[2:0];
            if (hit(a, OFF_MONCLR))  mon_clr_o   <= pwdata[7:0];
            if (hit(a, OFF_INJ_SYN)) inj_syn_o   <= pwdata[SYN_W-1:0];
            if (hit(a, OFF_INJ_CNT)) inj_cnt_o   <= pwdata[INJ_W-1:0];
            if (hit(a, OFF_MRG_RD))  mrg_rd_o    <= pwdata[3*BANKS-1:0];
            if (hit(a, OFF_MRG_WR))  mrg_wr_o    <= pwdata[2*BANKS-1:0];
            if (hit(a, OFF_MRG_SN))  mrg_sense_o <= pwdata[BANKS-1:0];
            for (int k = 0; k < DWORDS; k++) begin
                if (hit(a, OFF_INJ_D0 + 4*k)) inj_data_o[32*k +: 32] <= pwdata;
            end
        end
    end

    // read mux
    always_comb begin
        prdata = '0;
        case (1'b1)
            hit(a, OFF_RESP):    prdata[3:0]         = err_resp_o;
            hit(a, OFF_STATUS):  prdata[NSRC-1:0]    = status_q;
            hit(a, OFF_MASK):    prdata[NSRC-1:0]    = mask_q;
            hit(a, OFF_ECCMODE): prdata[2:0]         = ecc_mode_o;
            hit(a, OFF_MONCLR):  prdata[7:0]         = mon_clr_o;
            hit(a, OFF_CE_ADDR): prdata[MEM_AW-1:0]  = ce_addr_q;
            hit(a, OFF_CE_SYN):  prdata[SYN_W-1:0]   = ce_syn_q;
            hit(a, OFF_UE_ADDR): prdata[MEM_AW-1:0]  = ue_addr_q;
            hit(a, OFF_UE_SYN):  prdata[SYN_W-1:0]   = ue_syn_q;
            hit(a, OFF_INJ_SYN): prdata[SYN_W-1:0]   = inj_syn_o;
            hit(a, OFF_MRG_RD):  prdata[3*BANKS-1:0] = mrg_rd_o;
            hit(a, OFF_MRG_WR):  prdata[2*BANKS-1:0] = mrg_wr_o;
            hit(a, OFF_MRG_SN):  prdata[BANKS-1:0]   = mrg_sense_o;
            hit(a, OFF_CE_CNT):  prdata[CNT_W-1:0]   = cnt_q;
            hit(a, OFF_RMW):     prdata[MEM_AW-1:0]  = rmw_q;
            hit(a, OFF_INJ_CNT): prdata[INJ_W-1:0]   = inj_cnt_o;
            hit(a, OFF_SIZE):    prdata[3:0]         = SIZE_CODE;
            default:             prdata              = '0;
        endcase
        for (int k = 0; k < DWORDS; k++) begin
            if (hit(a, OFF_CE_D0 + 4*k))  prdata = ce_data_q[32*k +: 32];
            if (hit(a, OFF_UE_D0 + 4*k))  prdata = ue_data_q[32*k +: 32];
            if (hit(a, OFF_INJ_D0 + 4*k)) prdata = inj_data_o[32*k +: 32];
        end
    end

endmodule

// File: tb/mem_err_regbank_bench.sv
module mem_err_regbank_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0]  paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata;
    logic [10:0]  evt = '0;
    logic [17:0]  ce_addr = '0, ue_addr = '0, rmw_addr = '0;
    logic [127:0] ce_data = '0, ue_data = '0;
    logic [15:0]  ce_syn = '0, ue_syn = '0;
    logic         irq;
    logic [3:0]   err_resp_o;
    logic [2:0]   ecc_mode_o;
    logic [7:0]   mon_clr_o;
    logic [127:0] inj_data_o;
    logic [15:0]  inj_syn_o;
    logic [23:0]  inj_cnt_o;
    logic [11:0]  mrg_rd_o;
    logic [7:0]   mrg_wr_o;
    logic [3:0]   mrg_sense_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mem_err_regbank u_mem_err_regbank (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .evt(evt),
        .ce_addr(ce_addr), .ce_data(ce_data), .ce_syn(ce_syn),
        .ue_addr(ue_addr), .ue_data(ue_data), .ue_syn(ue_syn), .rmw_addr(rmw_addr),
        .irq(irq), .err_resp_o(err_resp_o), .ecc_mode_o(ecc_mode_o), .mon_clr_o(mon_clr_o),
        .inj_data_o(inj_data_o), .inj_syn_o(inj_syn_o), .inj_cnt_o(inj_cnt_o),
        .mrg_rd_o(mrg_rd_o), .mrg_wr_o(mrg_wr_o), .mrg_sense_o(mrg_sense_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data during each read enable phase
    always @(negedge clk) begin
        if (psel && penable && !pwrite && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, prdata, e);
        end
    end

    task automatic apb_wr(logic [11:0] a, logic [31:0] d, logic [10:0] ev = '0);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1; evt = ev;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; evt = '0;
    endtask

    task automatic apb_rd(logic [11:0] a, logic [31:0] exp, string req);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        exp_q.push_back(exp);
        tag_q.push_back($sformatf("%s @%h", req, a));
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse(logic [10:0] ev);
        @(posedge clk); #1;
        evt = ev;
        @(posedge clk); #1;
        evt = '0;
    endtask

    task automatic chk_irq(logic exp, string req);
        @(negedge clk);
        check(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 / R9: reset state
        chk_irq(1'b0, "R2 irq reset");
        apb_rd(12'h004, 32'h0, "R2 status reset");
        apb_rd(12'h008, 32'h7FF, "R2 mask reset");
        apb_rd(12'h060, 32'h249, "R2 read margin reset");
        apb_rd(12'h06C, 32'h0, "R2 counter reset");
        apb_rd(12'h080, 32'h2, "R9 size code");
        apb_wr(12'h080, 32'hF);
        apb_rd(12'h080, 32'h2, "R9 size read-only");

        // R3 / R5: event sets bit, W1C, irq follows
        pulse(11'h001);
        chk_irq(1'b1, "R5 irq on event");
        apb_rd(12'h004, 32'h1, "R3 event sets bit0");
        apb_rd(12'h006, 32'h1, "R1 low address bits ignored");
        apb_wr(12'h004, 32'hFFFF_FFFE);
        apb_rd(12'h004, 32'h1, "R3 write zero keeps bit");
        apb_wr(12'h004, 32'h1);
        apb_rd(12'h004, 32'h0, "R3 write one clears");
        chk_irq(1'b0, "R5 irq drops after clear");

        // R4 / R5: mask aliases
        apb_wr(12'h010, 32'h7FF);
        apb_rd(12'h008, 32'h0, "R4 disable alias");
        apb_rd(12'h010, 32'h0, "R4 disable alias reads zero");
        pulse(11'h008);
        chk_irq(1'b0, "R5 masked source no irq");
        apb_wr(12'h00C, 32'h8);
        apb_rd(12'h008, 32'h8, "R4 enable alias");
        apb_rd(12'h00C, 32'h0, "R4 enable alias reads zero");
        chk_irq(1'b1, "R5 irq after enable");
        apb_wr(12'h008, 32'h0);
        apb_rd(12'h008, 32'h8, "R4 direct mask write ignored");
        apb_wr(12'h00C, 32'h7FF);
        apb_wr(12'h004, 32'h7FF);

        // R3: set wins over same-cycle clear
        pulse(11'h020);
        apb_wr(12'h004, 32'h20, 11'h020);
        apb_rd(12'h004, 32'h20, "R3 set wins over clear");
        apb_wr(12'h004, 32'h20);
        apb_rd(12'h004, 32'h0, "R3 cleared afterwards");

        // R6 / R8: first correctable failure kept
        @(posedge clk); #1;
        ce_addr = 18'h1_2345; ce_syn = 16'hA5C3;
        ce_data = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
        pulse(11'h040);
        ce_addr = 18'h0_0BAD; ce_syn = 16'h0001; ce_data = '1;
        pulse(11'h040);
        apb_rd(12'h01C, 32'h1_2345, "R6 first address kept");
        apb_rd(12'h020, 32'h1111_1111, "R6 data word0");
        apb_rd(12'h02C, 32'h4444_4444, "R6 data word3");
        apb_rd(12'h030, 32'hA5C3, "R6 syndrome kept");
        apb_rd(12'h06C, 32'h2, "R8 count two events");
        apb_wr(12'h01C, 32'hFFFF_FFFF);
        apb_rd(12'h01C, 32'h1_2345, "R6 capture write ignored");
        apb_wr(12'h004, 32'h40);
        ce_addr = 18'h3_0F0F;
        pulse(11'h040);
        apb_rd(12'h01C, 32'h3_0F0F, "R6 re-armed after clear");
        apb_wr(12'h06C, 32'h1);
        apb_rd(12'h06C, 32'h2, "R8 W1C count bit0");
        apb_wr(12'h06C, 32'hFFFF);
        apb_rd(12'h06C, 32'h0, "R8 count cleared");

        // R7: uncorrectable and RMW capture
        @(posedge clk); #1;
        ue_addr = 18'h2_AAAA; ue_syn = 16'h5A5A; rmw_addr = 18'h0_1357;
        ue_data = 128'hDDDD_0000_CCCC_0000_BBBB_0000_AAAA_0000;
        pulse(11'h480);
        ue_addr = 18'h0; rmw_addr = 18'h0;
        pulse(11'h480);
        apb_rd(12'h034, 32'h2_AAAA, "R7 UE address");
        apb_rd(12'h038, 32'hAAAA_0000, "R7 UE data word0");
        apb_rd(12'h044, 32'hDDDD_0000, "R7 UE data word3");
        apb_rd(12'h048, 32'h5A5A, "R7 UE syndrome");
        apb_rd(12'h070, 32'h0_1357, "R7 RMW address");
        apb_wr(12'h004, 32'h7FF);

        // R10: control registers
        apb_wr(12'h000, 32'hFFFF_FFFF);
        apb_rd(12'h000, 32'hF, "R10 error response");
        @(negedge clk); check("R10 err_resp_o", {28'd0, err_resp_o}, 32'hF);
        apb_wr(12'h014, 32'hFFFF_FFFD);
        apb_rd(12'h014, 32'h5, "R10 ECC mode");
        apb_wr(12'h018, 32'h1234_56A5);
        apb_rd(12'h018, 32'hA5, "R10 monitor clear");
        apb_wr(12'h054, 32'hCAFE_F00D);
        apb_rd(12'h054, 32'hCAFE_F00D, "R10 injection word2");
        @(negedge clk); check("R10 inj_data_o word2", inj_data_o[95:64], 32'hCAFE_F00D);
        apb_wr(12'h05C, 32'h1234_BEEF);
        apb_rd(12'h05C, 32'hBEEF, "R10 injection syndrome");
        apb_wr(12'h060, 32'hFFFF_F0A3);
        apb_rd(12'h060, 32'h0A3, "R10 read margin");
        apb_wr(12'h064, 32'h1FF);
        apb_rd(12'h064, 32'hFF, "R10 write margin");
        apb_wr(12'h068, 32'h3);
        apb_rd(12'h068, 32'h3, "R10 sense margin");
        apb_wr(12'h074, 32'hFFFF_FFFF);
        apb_rd(12'h074, 32'hFF_FFFF, "R10 injection counter");

        // R11: undecoded offsets
        apb_wr(12'h078, 32'hFFFF_FFFF);
        apb_rd(12'h078, 32'h0, "R11 undecoded reads zero");
        apb_rd(12'h084, 32'h0, "R11 undecoded 0x84");
        apb_rd(12'h000, 32'hF, "R11 write elsewhere no effect");
        apb_rd(12'h074, 32'hFF_FFFF, "R11 counter untouched");

        // R8: saturation with a held pulse
        @(posedge clk); #1;
        evt = 11'h040;
        repeat (65540) @(posedge clk);
        #1 evt = '0;
        apb_rd(12'h06C, 32'hFFFF, "R8 saturates");
        pulse(11'h040);
        apb_rd(12'h06C, 32'hFFFF, "R8 stays saturated");

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R1: actual %0d reads unchecked expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule